// File: doc/BRIEF.md
# Analog Acquisition Control and Status Register

This block sits on a small register bus in front of a multiplexed analog input front end. It holds one 16-bit control word. The word sets the acquisition mode, the amplifier gain and a 5-bit channel code. The block decodes that word into the controls the front end needs: a one-hot row select with its binary index, a differential-pair enable, a one-hot calibration-source select, an auto-zero select, a two-bit gain code and a flag for codes that select nothing.

A second bus location acts as a convert command. Any write to it starts a conversion. An external trigger input, synchronized and edge detected inside the block, does the same. Either source produces a one-cycle convert-start pulse and sets a sticky "conversion triggered" flag. The flag reads back in the top bit of the control word. Only the converter's result-read strobe clears it.

Top module: `acq_ctrl_reg`

## Requirements
- R1: A read (`bus_rd`) at control offset 0x00 returns bits 14:0 exactly as last written there, in the same cycle. Bits 14:10 and bit 5 have no function but are stored. The control word holds no defined value after reset, so software programs it before acquiring.
- R2: Bit 15 of the control readback is the conversion-triggered flag. Writing bit 15 at offset 0x00 changes neither the flag nor any output.
- R3: With mode bits 9:8 = 00 and channel code {bit4..bit0} of 0..19, `mux_en`=1, `diff_en`=1, `mux_idx` equals the code, and `mux_onehot` has only that bit set.
- R4: With mode 01 and code 0..19, the block selects single-ended row index = code. With mode 10 and code 0..19, it selects index = code + 20. In both cases `diff_en`=0.
- R5: With mode 00 and code 20..23, `cal_onehot` bit (code - 20) is the only bit set, and `mux_en`=0.
- R6: With mode 11, `autozero_en`=1 and `mux_onehot`, `cal_onehot`, `mux_en`, `diff_en` and `sel_invalid` are all 0, whatever the channel code.
- R7: `gain_code` equals bits 7:6 (00 gain 1, 01 gain 2, 10 gain 4, 11 gain 8).
- R8: Codes 24..31 in modes 00, 01 and 10, and codes 20..23 in modes 01 and 10, set `sel_invalid`=1 and drive no row and no calibration source.
- R9: A write of any data to offset 0x10 makes `conv_start` high for exactly the one cycle after the write cycle. The same clock edge sets the flag.
- R10: A read at offset 0x10 returns all zeros, as does a read at any unmapped offset.
- R11: A rising edge on `ext_trig` makes `conv_start` high on the third rising clock edge after the input changes. It also sets the flag. A level held high gives only one pulse.
- R12: `result_rd` clears the flag at the next edge. A trigger in the same cycle wins and leaves the flag set. A trigger while the flag is already set still pulses `conv_start`.
- R13: During and after reset, `conv_start`=0 and the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not reading a mapped control word |
| result_rd | input | 1 | Converter result-read strobe, clears the flag |
| ext_trig | input | 1 | Asynchronous external trigger level |
| conv_start | output | 1 | One-cycle convert-start pulse |
| gain_code | output | 2 | Amplifier gain code |
| mux_onehot | output | 40 | One-hot input row select |
| mux_idx | output | 6 | Binary index of the selected row |
| mux_en | output | 1 | A row is selected |
| diff_en | output | 1 | Selected row is used as a differential pair |
| cal_onehot | output | 4 | One-hot calibration source select |
| autozero_en | output | 1 | Auto-zero input selected |
| sel_invalid | output | 1 | Mode and code select nothing |

## Verification
The assertions assume that the bus strobes are single-cycle and never carry X. They also assume `ext_trig` is the only asynchronous input. The stimulus keeps to this by changing every input only on the falling clock edge, and by raising the bus strobes one access at a time. The stimulus writes the control word before it reads back or decodes anything, so the undefined reset contents never reach a check. The trigger sequences keep `ext_trig` high for several cycles, so the synchronizer always sees a clean edge.

// File: rtl/acq_ctrl_pkg.sv
// Package: shared field layout and mode encoding of the acquisition control word.
// Assumes the bit positions of the word are fixed by software and the front end.
package acq_ctrl_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        MODE_DIFF  = 2'b00,
        MODE_SE_LO = 2'b01,
        MODE_SE_HI = 2'b10,
        MODE_AZERO = 2'b11
    } acq_mode_e;

    // Stored bits 14:0 of the control word, most significant first.
    typedef struct packed {
        logic [4:0]        spare_hi;
        acq_mode_e         mode;
        logic [1:0]        gain;
        logic              spare_lo;
        logic [CODE_W-1:0] code;
    } ctrl_fields_t;

endpackage

// File: rtl/acq_trig_sync.sv
// Module: synchronizes an asynchronous trigger level and emits a one-cycle
// pulse on its rising edge. Assumes STAGES >= 2.
module acq_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/acq_status_flag.sv
// Module: sticky conversion-triggered flag and registered convert-start pulse.
// Assumes trig and clear are synchronous single-cycle events; trig wins.
module acq_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clear,
    output logic flag,
    output logic start_pulse
);

    // Set on any trigger, clear on a result read without a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (trig) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end

    // Pass every trigger on as a one-cycle start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= trig;
        end
    end

endmodule

// File: rtl/acq_chan_decode.sv
// Module: decodes mode and channel code into row, calibration and auto-zero
// selects. Purely combinational. Assumes CHAN_PER_BANK + NUM_CAL <= 32.
module acq_chan_decode
    import acq_ctrl_pkg::*;
#(
    parameter  int CHAN_PER_BANK = 20,
    parameter  int NUM_CAL       = 4,
    localparam int NUM_CH        = 2 * CHAN_PER_BANK,
    localparam int IDX_W         = $clog2(NUM_CH),
    localparam int CAL_W         = (NUM_CAL > 1) ? $clog2(NUM_CAL) : 1
) (
    input  acq_mode_e          mode,
    input  logic [CODE_W-1:0]  code,
    output logic [NUM_CH-1:0]  mux_onehot,
    output logic [IDX_W-1:0]   mux_idx,
    output logic               mux_en,
    output logic               diff_en,
    output logic [NUM_CAL-1:0] cal_onehot,
    output logic               autozero_en,
    output logic               sel_invalid
);

    logic             in_bank;
    logic             in_cal;
    logic             cal_hit;
    logic [CAL_W-1:0] cal_ofs;

    // Classify the channel code against the bank and calibration ranges.
    always_comb begin
        in_bank = int'(code) < CHAN_PER_BANK;
        in_cal  = (int'(code) >= CHAN_PER_BANK) &&
                  (int'(code) <  CHAN_PER_BANK + NUM_CAL);
        cal_ofs = CAL_W'(int'(code) - CHAN_PER_BANK);
    end

    // Resolve the selection for the active mode; auto-zero overrides the code.
    always_comb begin
        mux_en      = 1'b0;
        diff_en     = 1'b0;
        mux_idx     = '0;
        cal_hit     = 1'b0;
        autozero_en = 1'b0;
        sel_invalid = 1'b0;
        unique case (mode)
            MODE_DIFF: begin
                if (in_bank) begin
                    mux_en  = 1'b1;
                    diff_en = 1'b1;
                    mux_idx = IDX_W'(code);
                end else if (in_cal) begin
                    cal_hit = 1'b1;
                end else begin
                    sel_invalid = 1'b1;
                end
            end
            MODE_SE_LO: begin
                if (in_bank) begin
                    mux_en  = 1'b1;
                    mux_idx = IDX_W'(code);
                end else begin
                    sel_invalid = 1'b1;
                end
            end
            MODE_SE_HI: begin
                if (in_bank) begin
                    mux_en  = 1'b1;
                    mux_idx = IDX_W'(code) + IDX_W'(CHAN_PER_BANK);
                end else begin
                    sel_invalid = 1'b1;
                end
            end
            MODE_AZERO: begin
                autozero_en = 1'b1;
            end
            default: begin
                sel_invalid = 1'b1;
            end
        endcase
    end

    // One row line per input channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_row
        assign mux_onehot[g] = mux_en && (mux_idx == IDX_W'(g));
    end

    // One select line per calibration source.
    for (genvar g = 0; g < NUM_CAL; g++) begin : g_cal
        assign cal_onehot[g] = cal_hit && (cal_ofs == CAL_W'(g));
    end

endmodule

// File: rtl/acq_ctrl_reg.sv
// Module: bus-mapped acquisition control/status register with convert command.
// Assumes single-cycle bus strobes; the control word is not reset and must be
// written by software before use; ext_trig may be asynchronous.
module acq_ctrl_reg
    import acq_ctrl_pkg::*;
#(
    parameter  int ADDR_W        = 5,
    parameter  int CTRL_OFS      = 'h00,
    parameter  int CONV_OFS      = 'h10,
    parameter  int CHAN_PER_BANK = 20,
    parameter  int NUM_CAL       = 4,
    parameter  int SYNC_STAGES   = 2,
    localparam int NUM_CH        = 2 * CHAN_PER_BANK,
    localparam int IDX_W         = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               result_rd,
    input  logic               ext_trig,
    output logic               conv_start,
    output logic [1:0]         gain_code,
    output logic [NUM_CH-1:0]  mux_onehot,
    output logic [IDX_W-1:0]   mux_idx,
    output logic               mux_en,
    output logic               diff_en,
    output logic [NUM_CAL-1:0] cal_onehot,
    output logic               autozero_en,
    output logic               sel_invalid
);

    logic               ctrl_hit;
    logic               conv_hit;
    logic               sw_conv;
    logic               ext_rise;
    logic               trig_evt;
    logic               flag_q;
    logic [WORD_W-2:0]  ctrl_q;
    ctrl_fields_t       fields;

    // Decode the two mapped offsets.
    always_comb begin
        ctrl_hit = bus_addr == ADDR_W'(CTRL_OFS);
        conv_hit = bus_addr == ADDR_W'(CONV_OFS);
        sw_conv  = bus_wr && conv_hit;
        trig_evt = sw_conv || ext_rise;
    end

    // Store bits 14:0 of a control write; bit 15 is status and is dropped.
    always_ff @(posedge clk) begin
        if (bus_wr && ctrl_hit) begin
            ctrl_q <= bus_wdata[WORD_W-2:0];
        end
    end

    assign fields = ctrl_fields_t'(ctrl_q);

    // Return the status flag and stored bits; nothing else answers a read.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && ctrl_hit) begin
            bus_rdata = {flag_q, ctrl_q};
        end
    end

    assign gain_code = fields.gain;

    acq_trig_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (ext_rise)
    );

    acq_status_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig_evt),
        .clear       (result_rd),
        .flag        (flag_q),
        .start_pulse (conv_start)
    );

    acq_chan_decode #(
        .CHAN_PER_BANK (CHAN_PER_BANK),
        .NUM_CAL       (NUM_CAL)
    ) u_dec (
        .mode        (fields.mode),
        .code        (fields.code),
        .mux_onehot  (mux_onehot),
        .mux_idx     (mux_idx),
        .mux_en      (mux_en),
        .diff_en     (diff_en),
        .cal_onehot  (cal_onehot),
        .autozero_en (autozero_en),
        .sel_invalid (sel_invalid)
    );

endmodule

// File: rtl/acq_ctrl_chk.sv
// Module: property checker for acq_ctrl_reg, attached by bind.
// Assumes the bound signals are X-free once reset has been applied.
module acq_ctrl_chk #(
    parameter int ADDR_W        = 5,
    parameter int CONV_OFS      = 'h10,
    parameter int CHAN_PER_BANK = 20,
    parameter int NUM_CAL       = 4,
    parameter int NUM_CH        = 40,
    parameter int IDX_W         = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic [15:0]        bus_rdata,
    input logic               result_rd,
    input logic               conv_start,
    input logic               flag,
    input logic [1:0]         mode,
    input logic [NUM_CH-1:0]  mux_onehot,
    input logic [IDX_W-1:0]   mux_idx,
    input logic               mux_en,
    input logic [NUM_CAL-1:0] cal_onehot,
    input logic               autozero_en,
    input logic               sel_invalid
);

    // R3: at most one row, and a row exactly when enabled
    p_row_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mux_onehot) && (mux_en == (mux_onehot != '0)));

    // R4: the high single-ended bank only uses the upper rows
    p_hi_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_en && mode == 2'b10) |-> (int'(mux_idx) >= CHAN_PER_BANK));

    // R5: calibration sources only in differential mode, one at a time
    p_cal_diff_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_onehot != '0) |-> (mode == 2'b00 && $onehot(cal_onehot) && !mux_en));

    // R6: auto-zero excludes every other select
    p_azero_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        autozero_en |-> (mode == 2'b11 && mux_onehot == '0 &&
                         cal_onehot == '0 && !sel_invalid));

    // R8: an invalid code drives nothing
    p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_invalid |-> (mux_onehot == '0 && cal_onehot == '0 && !autozero_en));

    // R10: the convert location never answers a read
    p_conv_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(CONV_OFS)) |-> (bus_rdata == '0));

    // R9: the flag only rises together with a start pulse
    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> conv_start);

    // R12: a start pulse always leaves the flag set
    p_start_sets_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> flag);

    // R12: the flag only falls after a result read
    p_flag_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(result_rd));

endmodule

bind acq_ctrl_reg acq_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CONV_OFS      (CONV_OFS),
    .CHAN_PER_BANK (CHAN_PER_BANK),
    .NUM_CAL       (NUM_CAL),
    .NUM_CH        (NUM_CH),
    .IDX_W         (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .result_rd   (result_rd),
    .conv_start  (conv_start),
    .flag        (flag_q),
    .mode        (ctrl_q[9:8]),
    .mux_onehot  (mux_onehot),
    .mux_idx     (mux_idx),
    .mux_en      (mux_en),
    .cal_onehot  (cal_onehot),
    .autozero_en (autozero_en),
    .sel_invalid (sel_invalid)
);

// File: tb/test_acq_ctrl_reg.sv
module test_acq_ctrl_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        result_rd = 1'b0;
    logic        ext_trig = 1'b0;
    logic        conv_start;
    logic [1:0]  gain_code;
    logic [39:0] mux_onehot;
    logic [5:0]  mux_idx;
    logic        mux_en;
    logic        diff_en;
    logic [3:0]  cal_onehot;
    logic        autozero_en;
    logic        sel_invalid;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    acq_ctrl_reg i_acq_ctrl_reg (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .result_rd (result_rd), .ext_trig (ext_trig), .conv_start (conv_start),
        .gain_code (gain_code), .mux_onehot (mux_onehot), .mux_idx (mux_idx),
        .mux_en (mux_en), .diff_en (diff_en), .cal_onehot (cal_onehot),
        .autozero_en (autozero_en), .sel_invalid (sel_invalid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected decode for one mode, code, gain, computed from the requirements.
    task automatic check_decode(input int mode, input int code, input int gain);
        bit        e_en = 0, e_diff = 0, e_az = 0, e_inv = 0;
        int        e_idx = 0;
        logic [3:0]  e_cal = '0;
        logic [39:0] e_row;
        if (mode == 3) e_az = 1;
        else if (code < 20) begin
            e_en = 1; e_diff = (mode == 0); e_idx = (mode == 2) ? code + 20 : code;
        end else if (mode == 0 && code < 24) e_cal = 4'b1 << (code - 20);
        else e_inv = 1;
        e_row = e_en ? (40'b1 << e_idx) : '0;
        check(gain_code == 2'(gain), "R7 gain", gain_code, gain);
        if (mode == 3)
            check(autozero_en && mux_onehot == '0 && cal_onehot == '0 && !mux_en &&
                  !diff_en && !sel_invalid, "R6 autozero", {mux_onehot, 4'(cal_onehot)}, 0);
        else if (e_inv)
            check(sel_invalid && mux_onehot == '0 && cal_onehot == '0 && !mux_en,
                  "R8 invalid", {mux_onehot, 4'(cal_onehot)}, 0);
        else if (e_cal != '0)
            check(cal_onehot == e_cal && !mux_en && mux_onehot == '0 && !sel_invalid,
                  "R5 calibration", cal_onehot, e_cal);
        else if (mode == 0)
            check(mux_onehot == e_row && mux_idx == 6'(e_idx) && mux_en && diff_en,
                  "R3 differential", mux_onehot, e_row);
        else
            check(mux_onehot == e_row && mux_idx == 6'(e_idx) && mux_en && !diff_en &&
                  cal_onehot == '0, "R4 single-ended", mux_onehot, e_row);
        check(autozero_en == e_az && sel_invalid == e_inv, "R6 R8 flags",
              {autozero_en, sel_invalid}, {e_az, e_inv});
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        logic [15:0] wd;
        tick(4);
        // R13: reset state
        check(conv_start == 1'b0, "R13 start in reset", conv_start, 0);
        bus_read(5'h00, rd);
        check(rd[15] == 1'b0, "R13 flag in reset", rd[15], 0);
        rst_n = 1'b1;
        tick(2);
        check(conv_start == 1'b0, "R13 start after reset", conv_start, 0);

        // R1 R2 R3..R8: exhaustive sweep over mode, code and gain
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 32; c++) begin
                for (int g = 0; g < 4; g++) begin
                    wd = {1'b1, 5'((c * 7 + m) ^ g), 2'(m), 2'(g), 1'((c + g) & 1), 5'(c)};
                    bus_write(5'h00, wd);
                    check(conv_start == 1'b0, "R2 bit15 write no start", conv_start, 0);
                    bus_read(5'h00, rd);
                    check(rd == {1'b0, wd[14:0]}, "R1 R2 readback", rd, {1'b0, wd[14:0]});
                    check_decode(m, c, g);
                end
            end
        end

        // R10: convert and unmapped offsets read zero
        bus_read(5'h10, rd);
        check(rd == 16'h0, "R10 convert read", rd, 0);
        bus_read(5'h04, rd);
        check(rd == 16'h0, "R10 unmapped read", rd, 0);

        // R9: software convert command
        bus_write(5'h10, 16'h1234);
        check(conv_start == 1'b1, "R9 start pulse", conv_start, 1);
        bus_read(5'h00, rd);
        check(rd[15] == 1'b1, "R9 flag set", rd[15], 1);
        tick(1);
        check(conv_start == 1'b0, "R9 single pulse", conv_start, 0);

        // R12: result read clears the flag
        result_rd = 1'b1;
        tick(1);
        result_rd = 1'b0;
        bus_read(5'h00, rd);
        check(rd[15] == 1'b0, "R12 clear on read", rd[15], 0);

        // R11: external trigger edge through the synchronizer
        ext_trig = 1'b1;
        tick(2);
        check(conv_start == 1'b0, "R11 no early start", conv_start, 0);
        tick(1);
        check(conv_start == 1'b1, "R11 start on third edge", conv_start, 1);
        bus_read(5'h00, rd);
        check(rd[15] == 1'b1, "R11 flag set", rd[15], 1);
        tick(1);
        check(conv_start == 1'b0, "R11 single pulse", conv_start, 0);
        for (int i = 0; i < 5; i++) begin
            tick(1);
            check(conv_start == 1'b0, "R11 held level no repeat", conv_start, 0);
        end
        ext_trig = 1'b0;
        tick(3);

        // R12: trigger while flag already set still pulses
        bus_write(5'h10, 16'hFFFF);
        check(conv_start == 1'b1, "R12 retrigger pulse", conv_start, 1);

        // R12: trigger and result read in the same cycle, trigger wins
        @(negedge clk);
        bus_addr = 5'h10; bus_wr = 1'b1; result_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; result_rd = 1'b0;
        bus_read(5'h00, rd);
        check(rd[15] == 1'b1, "R12 trigger beats clear", rd[15], 1);
        check(conv_start == 1'b1, "R12 pulse on collision", conv_start, 1);

        // R2: writing bit 15 low leaves the flag set
        bus_write(5'h00, 16'h0000);
        bus_read(5'h00, rd);
        check(rd == 16'h8000, "R2 flag survives write", rd, 16'h8000);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule